// File: doc/BRIEF.md
# FIFO Status and Interrupt Controller

This block sits between a serial shift engine and a simple register port. It owns a transmit FIFO that software fills through register writes and the engine drains, and a receive FIFO that the engine fills and software drains through register reads. Around the two FIFOs it generates a status word, fill levels, level-driven interrupts against programmable thresholds, and sticky error flags for overflow and underflow. The error flags are cleared through a write-to-clear register, either one at a time or all at once.

A single enable bit gates all FIFO activity. While it is low both FIFOs are held empty and every push or pop is dropped. The threshold registers may only be changed while the block is disabled. Raw interrupt status is combined with a mask into one interrupt output line.

Register addresses on `regAddr`: 0 control (bit0 enable), 1 transmit threshold, 2 receive threshold, 3 transmit fill level, 4 receive fill level, 5 status, 6 interrupt mask, 7 masked status, 8 raw status, 9 clear, 10 transmit data (write), 11 receive data (read). Reads are combinational on `regRdData` while `regRdEn` is high.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset the control, thresholds, mask and both fill levels (addresses 0 to 4 and 6) read 0, status (address 5) reads 0x0C, raw status (address 8) reads 0x01, and `irqOut` is low.
- R2: Status bits are: bit0 busy (enabled and either transmit level nonzero or `engBusy` high), bit1 transmit FIFO full, bit2 transmit FIFO empty, bit3 receive FIFO empty, bit4 receive FIFO full. Full means a level equal to DEPTH, where DEPTH is 32 or 64.
- R3: Raw bit0 (transmit low) is set exactly while the transmit level is at or below the transmit threshold, and follows the level without latching.
- R4: Raw bit4 (receive high) is set exactly while the receive level is strictly above the receive threshold, so a threshold of N fires at N+1 entries.
- R5: A transmit data write while enabled and the transmit FIFO is full sets sticky raw bit1; the word is dropped and the level stays at DEPTH.
- R6: A receive data read while enabled and the receive FIFO is empty sets sticky raw bit2 and leaves the level at 0.
- R7: An engine push while enabled and the receive FIFO is full sets sticky raw bit3; the word is dropped and the stored words come out unchanged and in order.
- R8: A write to the clear register clears sticky bits: data bit0 clears all three, bit1 raw bit2, bit2 raw bit3, bit3 raw bit1. An error event in the same cycle as its clear leaves the bit set.
- R9: Masked status (address 7) equals raw status AND mask; `irqOut` is high exactly when any masked bit is set.
- R10: Writing 0 to the enable bit empties both FIFOs by the next cycle. While disabled, transmit writes and engine pushes leave the levels at 0, and sticky bits keep their values.
- R11: Threshold writes take effect only while the block is disabled; a write while enabled leaves the old value readable.
- R12: Both FIFOs are first-in first-out: `engTxData` shows the oldest transmit word and a receive data read returns the oldest received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 4 | Register address |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data |
| engTxPop | input | 1 | Engine takes the oldest transmit word |
| engTxData | output | DATA_W | Oldest transmit word |
| engTxAvail | output | 1 | Transmit FIFO not empty |
| engRxPush | input | 1 | Engine delivers a received word |
| engRxData | input | DATA_W | Received word |
| engBusy | input | 1 | Engine is shifting |
| engEnable | output | 1 | Block enable to the engine |
| irqOut | output | 1 | Combined interrupt |

## Verification
The case that can collide is a receive overflow event landing in the same cycle as a clear write that targets that very flag. The bench fills the receive FIFO, then raises the engine push and the clear write on the same clock edge, and expects raw bit3 still set afterwards; a second clear alone must then remove it. The scoreboard also checks that the overflow word never appears among the words read back.

// File: rtl/sfic_pkg.sv
package sfic_pkg;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic flush;
  } fifoStrobe_t;

  localparam int ADDR_W = 4;
  localparam int IRQ_W  = 5;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_TXTHR  = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_RXTHR  = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_TXLVL  = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_RXLVL  = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_MASK   = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_MASKED = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_RAW    = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_CLEAR  = 4'd9;
  localparam logic [ADDR_W-1:0] ADR_TXDATA = 4'd10;
  localparam logic [ADDR_W-1:0] ADR_RXDATA = 4'd11;

endpackage

// File: rtl/sfic_fifo.sv
module sfic_fifo #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] headData,
  output logic [LVL_W-1:0]  level
);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      level <= level + LVL_W'(push) - LVL_W'(pop);
    end
  end

  assign headData = store[rdPtr];

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));
  assert_no_push_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    push |-> level != LVL_W'(DEPTH));
  assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> level != '0);
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> level == '0);

endmodule

// File: rtl/sfic_datapath.sv
module sfic_datapath import sfic_pkg::*; #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 16,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] txWrData,
  input  logic [DATA_W-1:0] rxWrData,
  output logic [DATA_W-1:0] txHead,
  output logic [DATA_W-1:0] rxHead,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel,
  output logic              txFull,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              rxEmpty
);

  sfic_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) txFifo_i (
    .clk(clk), .rstN(rstN), .push(strobe.txPush), .pop(strobe.txPop),
    .flush(strobe.flush), .wrData(txWrData), .headData(txHead), .level(txLevel)
  );

  sfic_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) rxFifo_i (
    .clk(clk), .rstN(rstN), .push(strobe.rxPush), .pop(strobe.rxPop),
    .flush(strobe.flush), .wrData(rxWrData), .headData(rxHead), .level(rxLevel)
  );

  assign txFull  = txLevel == LVL_W'(DEPTH);
  assign txEmpty = txLevel == '0;
  assign rxFull  = rxLevel == LVL_W'(DEPTH);
  assign rxEmpty = rxLevel == '0;

endmodule

// File: rtl/sfic_control.sv
module sfic_control import sfic_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int LVL_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              engTxPop,
  input  logic              engRxPush,
  input  logic              engBusy,
  input  logic [DATA_W-1:0] rxHead,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic              txFull,
  input  logic              txEmpty,
  input  logic              rxFull,
  input  logic              rxEmpty,
  output fifoStrobe_t       strobe,
  output logic              enabled,
  output logic              irqOut
);

  logic             enQ, enNext;
  logic [LVL_W-1:0] txThrQ, rxThrQ;
  logic [IRQ_W-1:0] maskQ;
  logic             txOvfQ, rxUndQ, rxOvfQ;
  logic             wrCtrl, wrClear, wrTxData, rdRxData;
  logic             txOvfSet, rxUndSet, rxOvfSet;
  logic             txOvfClr, rxUndClr, rxOvfClr;
  logic [IRQ_W-1:0] rawIrq, maskedIrq, statusWord;

  assign wrCtrl   = regWrEn && regAddr == ADR_CTRL;
  assign wrClear  = regWrEn && regAddr == ADR_CLEAR;
  assign wrTxData = regWrEn && regAddr == ADR_TXDATA;
  assign rdRxData = regRdEn && regAddr == ADR_RXDATA;
  assign enNext   = wrCtrl ? regWrData[0] : enQ;

  always_comb begin
    strobe.txPush = enQ && wrTxData && !txFull;
    strobe.txPop  = enQ && engTxPop && !txEmpty;
    strobe.rxPush = enQ && engRxPush && !rxFull;
    strobe.rxPop  = enQ && rdRxData && !rxEmpty;
    strobe.flush  = !enNext;
  end

  assign txOvfSet = enQ && wrTxData && txFull;
  assign rxUndSet = enQ && rdRxData && rxEmpty;
  assign rxOvfSet = enQ && engRxPush && rxFull;
  assign txOvfClr = wrClear && (regWrData[0] || regWrData[3]);
  assign rxUndClr = wrClear && (regWrData[0] || regWrData[1]);
  assign rxOvfClr = wrClear && (regWrData[0] || regWrData[2]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      txThrQ <= '0;
      rxThrQ <= '0;
      maskQ  <= '0;
      txOvfQ <= 1'b0;
      rxUndQ <= 1'b0;
      rxOvfQ <= 1'b0;
    end else begin
      enQ <= enNext;
      if (!enQ && regWrEn && regAddr == ADR_TXTHR) txThrQ <= regWrData[LVL_W-1:0];
      if (!enQ && regWrEn && regAddr == ADR_RXTHR) rxThrQ <= regWrData[LVL_W-1:0];
      if (regWrEn && regAddr == ADR_MASK) maskQ <= regWrData[IRQ_W-1:0];
      txOvfQ <= (txOvfQ && !txOvfClr) || txOvfSet;
      rxUndQ <= (rxUndQ && !rxUndClr) || rxUndSet;
      rxOvfQ <= (rxOvfQ && !rxOvfClr) || rxOvfSet;
    end
  end

  assign rawIrq     = {rxLevel > rxThrQ, rxOvfQ, rxUndQ, txOvfQ, txLevel <= txThrQ};
  assign maskedIrq  = rawIrq & maskQ;
  assign statusWord = {rxFull, rxEmpty, txEmpty, txFull, enQ && (!txEmpty || engBusy)};
  assign irqOut     = |maskedIrq;
  assign enabled    = enQ;

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      unique case (regAddr)
        ADR_CTRL:   regRdData = DATA_W'(enQ);
        ADR_TXTHR:  regRdData = DATA_W'(txThrQ);
        ADR_RXTHR:  regRdData = DATA_W'(rxThrQ);
        ADR_TXLVL:  regRdData = DATA_W'(txLevel);
        ADR_RXLVL:  regRdData = DATA_W'(rxLevel);
        ADR_STATUS: regRdData = DATA_W'(statusWord);
        ADR_MASK:   regRdData = DATA_W'(maskQ);
        ADR_MASKED: regRdData = DATA_W'(maskedIrq);
        ADR_RAW:    regRdData = DATA_W'(rawIrq);
        ADR_RXDATA: regRdData = rxEmpty ? '0 : rxHead;
        default:    regRdData = '0;
      endcase
    end
  end

  // sticky error flags hold until a matching clear
  assert_txovf_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txOvfQ && !txOvfClr) |=> txOvfQ);
  assert_rxund_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxUndQ && !rxUndClr) |=> rxUndQ);
  assert_rxovf_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && engRxPush && rxFull) |=> rxOvfQ);
  assert_thr_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    enQ |=> $stable(txThrQ) && $stable(rxThrQ));

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl import sfic_pkg::*; #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 16,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [3:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              engTxPop,
  output logic [DATA_W-1:0] engTxData,
  output logic              engTxAvail,
  input  logic              engRxPush,
  input  logic [DATA_W-1:0] engRxData,
  input  logic              engBusy,
  output logic              engEnable,
  output logic              irqOut
);

  fifoStrobe_t       strobe;
  logic [DATA_W-1:0] rxHead;
  logic [LVL_W-1:0]  txLevel, rxLevel;
  logic              txFull, txEmpty, rxFull, rxEmpty;

  sfic_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txWrData(regWrData), .rxWrData(engRxData),
    .txHead(engTxData), .rxHead(rxHead),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty)
  );

  sfic_control #(.DATA_W(DATA_W), .LVL_W(LVL_W)) control_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .engTxPop(engTxPop), .engRxPush(engRxPush), .engBusy(engBusy),
    .rxHead(rxHead), .txLevel(txLevel), .rxLevel(rxLevel),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .strobe(strobe), .enabled(engEnable), .irqOut(irqOut)
  );

  assign engTxAvail = !txEmpty;

endmodule

// File: tb/fifo_irq_ctrl_tb_top.sv
`timescale 1ns/100ps
module fifo_irq_ctrl_tb_top;
  localparam int DEPTH = 32;
  localparam int DW    = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [DW-1:0] regWrData = '0, regRdData;
  logic engTxPop = 1'b0, engRxPush = 1'b0, engBusy = 1'b0;
  logic [DW-1:0] engTxData, engRxData = '0;
  logic engTxAvail, engEnable, irqOut;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [DW-1:0] txExp[$];
  logic [DW-1:0] rxExp[$];

  always #2.5 clk = ~clk;

  fifo_irq_ctrl #(.DEPTH(DEPTH), .DATA_W(DW)) dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [DW-1:0] v);
    @(negedge clk); regRdEn = 1'b1; regAddr = a;
    #0.5 v = regRdData;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [3:0] a, input int exp);
    logic [DW-1:0] v;
    rd(a, v);
    check(req, int'(v), exp);
  endtask

  // driver: transmit word, recorded unless it must be dropped
  task automatic pushTx(input logic [DW-1:0] d, input bit kept);
    wr(4'd10, d);
    if (kept) txExp.push_back(d);
  endtask

  task automatic engPush(input logic [DW-1:0] d, input bit kept);
    @(negedge clk); engRxPush = 1'b1; engRxData = d;
    @(negedge clk); engRxPush = 1'b0;
    if (kept) rxExp.push_back(d);
  endtask

  task automatic engPop();
    @(negedge clk); engTxPop = 1'b1;
    @(negedge clk); engTxPop = 1'b0;
  endtask

  // receive-side monitor through the read port
  task automatic readRx(input string req);
    logic [DW-1:0] v;
    rd(4'd11, v);
    if (rxExp.size() == 0) check({req, " unexpected rx"}, 1, 0);
    else check(req, int'(v), int'(rxExp.pop_front()));
  endtask

  // transmit-side monitor: compare every accepted engine pop (R12)
  always @(posedge clk) begin
    if (rstN && engTxPop && engTxAvail) begin
      if (txExp.size() == 0) check("R12 tx unexpected pop", 1, 0);
      else check("R12 tx order", int'(engTxData), int'(txExp.pop_front()));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rdCheck("R1 ctrl", 4'd0, 0);
    rdCheck("R1 txlvl", 4'd3, 0);
    rdCheck("R1 rxlvl", 4'd4, 0);
    rdCheck("R1 status", 4'd5, 'h0C);
    rdCheck("R1 raw", 4'd8, 'h01);
    rdCheck("R1 mask", 4'd6, 0);
    check("R1 irq", int'(irqOut), 0);

    // R11 thresholds
    wr(4'd1, 2); wr(4'd2, 3);
    rdCheck("R11 txthr disabled", 4'd1, 2);
    wr(4'd0, 1);
    wr(4'd1, 5);
    rdCheck("R11 txthr enabled write ignored", 4'd1, 2);
    check("R10 engEnable", int'(engEnable), 1);

    // R3 transmit low-level interrupt
    for (int i = 0; i < 3; i++) pushTx(DW'(16'h5000 + i), 1'b1);
    rdCheck("R3 raw above thr", 4'd8, 'h00);
    rdCheck("R2 status busy tx", 4'd5, 'h09);
    engPop();
    rdCheck("R3 raw at thr", 4'd8, 'h01);
    engPop(); engPop();
    engBusy = 1'b1;
    rdCheck("R2 status busy engine", 4'd5, 'h0D);
    engBusy = 1'b0;

    // R9 mask
    wr(4'd6, 'h01);
    rdCheck("R9 masked", 4'd7, 'h01);
    check("R9 irq on", int'(irqOut), 1);
    wr(4'd6, 'h10);
    check("R9 irq off", int'(irqOut), 0);

    // R4 receive high-level interrupt
    for (int i = 0; i < 3; i++) engPush(DW'(16'hA000 + i), 1'b1);
    rdCheck("R4 raw at thr", 4'd8, 'h01);
    engPush(16'hA003, 1'b1);
    rdCheck("R4 raw above thr", 4'd8, 'h11);
    check("R9 irq rx", int'(irqOut), 1);
    rdCheck("R2 status rx", 4'd5, 'h04);
    for (int i = 0; i < 4; i++) readRx("R12 rx order");

    // R6 underflow
    begin
      logic [DW-1:0] v;
      rd(4'd11, v);
    end
    rdCheck("R6 raw underflow", 4'd8, 'h05);
    rdCheck("R6 rxlvl", 4'd4, 0);

    // R5 transmit overflow
    for (int i = 0; i < DEPTH; i++) pushTx(DW'(16'h6000 + i), 1'b1);
    rdCheck("R2 status tx full", 4'd5, 'h0B);
    pushTx(16'hDEAD, 1'b0);
    rdCheck("R5 raw", 4'd8, 'h06);
    rdCheck("R5 txlvl", 4'd3, DEPTH);
    for (int i = 0; i < DEPTH; i++) engPop();
    check("R12 tx drained", txExp.size(), 0);

    // R7 receive overflow
    for (int i = 0; i < DEPTH; i++) engPush(DW'(16'hB000 + i), 1'b1);
    engPush(16'hBEEF, 1'b0);
    rdCheck("R7 raw", 4'd8, 'h1F);
    rdCheck("R7 rxlvl", 4'd4, DEPTH);
    rdCheck("R2 status rx full", 4'd5, 'h14);
    for (int i = 0; i < DEPTH; i++) readRx("R7 rx order");

    // R8 selective clear
    rdCheck("R8 raw before", 4'd8, 'h0F);
    wr(4'd9, 'h02);
    rdCheck("R8 clear underflow", 4'd8, 'h0B);
    wr(4'd9, 'h08);
    rdCheck("R8 clear tx overflow", 4'd8, 'h09);
    wr(4'd9, 'h01);
    rdCheck("R8 clear all", 4'd8, 'h01);

    // R8 set and clear in the same cycle
    for (int i = 0; i < DEPTH; i++) engPush(DW'(16'hC000 + i), 1'b1);
    @(negedge clk);
    engRxPush = 1'b1; engRxData = 16'hFACE;
    regWrEn = 1'b1; regAddr = 4'd9; regWrData = 'h04;
    @(negedge clk);
    engRxPush = 1'b0; regWrEn = 1'b0;
    rdCheck("R8 set wins over clear", 4'd8, 'h19);

    // R10 disable flushes, keeps sticky
    wr(4'd0, 0);
    rdCheck("R10 rxlvl flushed", 4'd4, 0);
    rdCheck("R10 sticky kept", 4'd8, 'h09);
    check("R10 engEnable off", int'(engEnable), 0);
    rxExp.delete();
    engPush(16'h1111, 1'b0);
    pushTx(16'h2222, 1'b0);
    rdCheck("R10 rx push ignored", 4'd4, 0);
    rdCheck("R10 tx write ignored", 4'd3, 0);
    wr(4'd9, 'h04);
    rdCheck("R8 clear rx overflow", 4'd8, 'h01);
    wr(4'd1, 7);
    rdCheck("R11 txthr disabled again", 4'd1, 7);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule